// File: doc/BRIEF.md
# Weighted TLP Class Transmit Arbiter

This block decides which of three outbound transaction classes owns the transmit link next. The three classes are completions, non-posted requests and posted requests. Each class presents its packets beat by beat on a valid/ready interface and marks the last beat of every packet. The arbiter forwards one class at a time onto a single link-side beat stream. It tags each beat with the class number and keeps the link on that class until the packet's final beat has been accepted.

The share of the link each class receives is set by a coarse per-class weight level. The levels are 0, 1 and 2, and they are written and read through a small register port. Writes above the top level saturate to 2. Writes whose sign bit is set are refused: an error pulse is raised and the stored level is kept. A level of w lets its class send up to w+1 back-to-back packets in each arbitration round. The rounds visit the classes in a fixed cyclic order. A class with nothing to send is passed over, and it forfeits the rest of its slots for that round. The weights shape proportions only; they do not promise exact ratios under changing load.

Top module: `wtx_arb`

## Requirements
- R1: Classes are numbered completion = 0, non-posted = 1, posted = 2. This number is used both for `link_cls` and for `cfg_addr`. A register write to address 3 changes nothing, and a read of address 3 returns 0.
- R2: After reset every stored weight level reads as 1, `cfg_err` is low, and with no class requesting `link_valid` is low.
- R3: A write with the sign bit (bit 7) clear stores min(value, 2). The read port combinationally returns the stored level of the addressed class, and that level never exceeds 2.
- R4: A write with bit 7 set leaves the stored level unchanged and drives `cfg_err` high for exactly the following cycle. Any other write leaves `cfg_err` low.
- R5: While every class keeps requesting, a class with level w receives exactly w+1 consecutive packets before the next class is served.
- R6: Rounds visit completion, then non-posted, then posted, then wrap to completion. The first packet after reset goes to the first requesting class in that order, starting from completion.
- R7: A class with no pending request is skipped without taking any slots. When only one class requests, it keeps being served round after round.
- R8: Once a packet's first beat is accepted, `link_cls` stays on that class until its last beat (`link_eop` high) is accepted.
- R9: While `link_valid` is high and `link_ready` is low, `link_cls` does not change in the next cycle.
- R10: At most one `cls_ready` bit is high. It is high only for the class in `link_cls`, only while `link_valid` and `link_ready` are both high. `link_data` and `link_eop` carry that class's beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cls_valid | input | 3 | Per-class beat valid, bit = class number |
| cls_data | input | 3*DATA_W | Per-class beat payload, class c in slice c |
| cls_eop | input | 3 | Per-class last-beat-of-packet marker |
| cls_ready | output | 3 | Per-class beat accepted this cycle |
| link_valid | output | 1 | Beat offered toward the link |
| link_data | output | DATA_W | Offered beat payload |
| link_eop | output | 1 | Offered beat is the packet's last |
| link_cls | output | 2 | Class of the offered beat |
| link_ready | input | 1 | Link accepts the offered beat |
| cfg_wr | input | 1 | Weight write strobe |
| cfg_addr | input | 2 | Class addressed for write and read |
| cfg_wdata | input | CFG_W | Signed weight value to write |
| cfg_rdata | output | 2 | Stored level of the addressed class |
| cfg_err | output | 1 | Previous-cycle write was refused |

## Verification
The hardest situation to reach from the ports is a round boundary that falls while the link is stalled in the middle of a multi-beat packet. A stray switch of class there would break both the slot count and packet integrity. The bench reaches it by sweeping all 27 weight combinations twice. The first pass uses single-beat packets and a link that is always ready. The second pass gives the classes packet lengths of 2, 1 and 3 beats and holds `link_ready` low every third cycle, so slot exhaustion keeps landing on stalled and partial packets. The logged packet order is then compared with the round schedule worked out arithmetically from the weights.

// File: rtl/wtx_arb_pkg.sv
// Shared constants and types for the weighted transmit-class arbiter.
// Assumes exactly three classes; the level width holds levels 0..2 plus
// one spare code used by the scheduler as an "exhausted" slot count.
package wtx_arb_pkg;
    localparam int NCLS  = 3;
    localparam int LVL_W = 2;
    localparam int CLS_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CLS_W-1:0] cls_idx_t;

    localparam lvl_t     LVL_MAX = lvl_t'(2);
    localparam cls_idx_t CLS_CPL = cls_idx_t'(0);
    localparam cls_idx_t CLS_NP  = cls_idx_t'(1);
    localparam cls_idx_t CLS_P   = cls_idx_t'(2);
endpackage

// File: rtl/wtx_weight_regs.sv
// Per-class weight level registers with saturating writes.
// Assumes cfg_wdata is two's complement; a set sign bit refuses the write
// and raises err for one cycle. Reads are combinational on addr.
module wtx_weight_regs
    import wtx_arb_pkg::*;
#(
    parameter int   CFG_W   = 8,
    parameter lvl_t RST_LVL = lvl_t'(1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [CLS_W-1:0]      addr,
    input  logic [CFG_W-1:0]      wdata,
    output lvl_t                  rdata,
    output logic                  err,
    output logic [NCLS*LVL_W-1:0] lvl_flat
);
    localparam int MAG_W = CFG_W - 1;

    logic             neg;
    logic [MAG_W-1:0] mag;
    lvl_t             clamped;
    lvl_t             lvl_q [NCLS];

    // Split the signed write value and saturate its magnitude to the top level.
    always_comb begin
        neg     = wdata[CFG_W-1];
        mag     = wdata[MAG_W-1:0];
        clamped = (mag > MAG_W'(LVL_MAX)) ? LVL_MAX : mag[LVL_W-1:0];
    end

    for (genvar i = 0; i < NCLS; i++) begin : g_lvl
        // Hold one class level; accept only non-negative writes to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i] <= RST_LVL;
            end else if (wr && !neg && addr == CLS_W'(i)) begin
                lvl_q[i] <= clamped;
            end
        end
        assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
    end

    // Flag a refused write for the cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= wr && neg;
        end
    end

    // Return the addressed level, zero for the unused address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (addr == CLS_W'(i)) begin
                rdata = lvl_q[i];
            end
        end
    end
endmodule

// File: rtl/wtx_round_sched.sv
// Round-based weighted scheduler. A class with level w gets up to w+1
// packets per visit; idle classes are skipped and lose their slots.
// The chosen class is committed when its first beat is offered and held
// until the last beat is accepted. Assumes a source keeps valid high
// from its first beat until its last beat is accepted.
module wtx_round_sched
    import wtx_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCLS-1:0]       req,
    input  logic [NCLS*LVL_W-1:0] lvl_flat,
    input  logic                  link_ready,
    input  logic                  eop_sel,
    output cls_idx_t              sel,
    output logic                  offer
);
    cls_idx_t cur_q;
    lvl_t     used_q;
    logic     lock_q;
    lvl_t     lvl [NCLS];
    cls_idx_t pick;
    logic     any;
    logic     fresh;
    logic     stay;

    for (genvar i = 0; i < NCLS; i++) begin : g_unpack
        assign lvl[i] = lvl_flat[i*LVL_W +: LVL_W];
    end

    // Choose: keep the current class while it has slots, else next requester in cyclic order.
    always_comb begin
        stay  = req[cur_q] && (used_q <= lvl[cur_q]);
        pick  = cur_q;
        any   = stay;
        fresh = 1'b0;
        for (int k = 1; k <= NCLS; k++) begin
            int idx;
            idx = (int'(cur_q) + k) % NCLS;
            if (!any && req[idx]) begin
                any   = 1'b1;
                pick  = cls_idx_t'(idx);
                fresh = 1'b1;
            end
        end
        sel   = lock_q ? cur_q : pick;
        offer = lock_q ? req[cur_q] : any;
    end

    // Commit a packet's class and slot count on its first offer; release on accepted last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= CLS_P;
            used_q <= '1;
            lock_q <= 1'b0;
        end else if (!lock_q) begin
            if (any) begin
                cur_q  <= pick;
                used_q <= fresh ? lvl_t'(1) : used_q + lvl_t'(1);
                lock_q <= !(link_ready && eop_sel);
            end
        end else if (req[cur_q] && link_ready && eop_sel) begin
            lock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wtx_beat_mux.sv
// Steers the selected class's beat onto the link and returns the
// handshake to that class only. Purely combinational.
module wtx_beat_mux
    import wtx_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cls_idx_t               sel,
    input  logic                   offer,
    input  logic                   link_ready,
    input  logic [NCLS*DATA_W-1:0] cls_data,
    input  logic [NCLS-1:0]        cls_eop,
    output logic [DATA_W-1:0]      link_data,
    output logic                   link_eop,
    output logic [NCLS-1:0]        cls_ready
);
    // Forward payload and end marker of the selected class.
    always_comb begin
        link_data = '0;
        link_eop  = 1'b0;
        for (int i = 0; i < NCLS; i++) begin
            if (sel == CLS_W'(i)) begin
                link_data = cls_data[i*DATA_W +: DATA_W];
                link_eop  = cls_eop[i];
            end
        end
    end

    for (genvar i = 0; i < NCLS; i++) begin : g_rdy
        assign cls_ready[i] = offer && link_ready && (sel == CLS_W'(i));
    end
endmodule

// File: rtl/wtx_arb.sv
// Top of the weighted transmit-class arbiter: weight registers, round
// scheduler and beat steering. Class 0 completion, 1 non-posted, 2 posted.
module wtx_arb
    import wtx_arb_pkg::*;
#(
    parameter int   DATA_W  = 32,
    parameter int   CFG_W   = 8,
    parameter lvl_t RST_LVL = lvl_t'(1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCLS-1:0]        cls_valid,
    input  logic [NCLS*DATA_W-1:0] cls_data,
    input  logic [NCLS-1:0]        cls_eop,
    output logic [NCLS-1:0]        cls_ready,
    output logic                   link_valid,
    output logic [DATA_W-1:0]      link_data,
    output logic                   link_eop,
    output logic [CLS_W-1:0]       link_cls,
    input  logic                   link_ready,
    input  logic                   cfg_wr,
    input  logic [CLS_W-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [LVL_W-1:0]       cfg_rdata,
    output logic                   cfg_err
);
    logic [NCLS*LVL_W-1:0] lvl_flat;
    cls_idx_t              sel;

    wtx_weight_regs #(.CFG_W(CFG_W), .RST_LVL(RST_LVL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .err      (cfg_err),
        .lvl_flat (lvl_flat)
    );

    wtx_round_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cls_valid),
        .lvl_flat   (lvl_flat),
        .link_ready (link_ready),
        .eop_sel    (link_eop),
        .sel        (sel),
        .offer      (link_valid)
    );

    wtx_beat_mux #(.DATA_W(DATA_W)) u_mux (
        .sel        (sel),
        .offer      (link_valid),
        .link_ready (link_ready),
        .cls_data   (cls_data),
        .cls_eop    (cls_eop),
        .link_data  (link_data),
        .link_eop   (link_eop),
        .cls_ready  (cls_ready)
    );

    assign link_cls = sel;
endmodule

// File: rtl/wtx_arb_chk.sv
// Property checker for wtx_arb, attached by bind. Observes ports only.
module wtx_arb_chk
    import wtx_arb_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCLS-1:0]  cls_ready,
    input logic             link_valid,
    input logic             link_ready,
    input logic             link_eop,
    input logic [CLS_W-1:0] link_cls,
    input logic             cfg_wr,
    input logic [CLS_W-1:0] cfg_addr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [LVL_W-1:0] cfg_rdata,
    input logic             cfg_err
);
    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_ready)); // R10
    AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|cls_ready) |-> (link_valid && link_ready && cls_ready == (NCLS'(1) << link_cls))); // R10
    AST_TLP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && link_ready && !link_eop) |=> (link_cls == $past(link_cls))); // R8
    AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !link_ready) |=> (link_cls == $past(link_cls))); // R9
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata <= LVL_MAX); // R3
    AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[CFG_W-1] && cfg_addr < CLS_W'(NCLS)) |=>
        ((cfg_addr != $past(cfg_addr)) ||
         (cfg_rdata == (($past(cfg_wdata) > CFG_W'(LVL_MAX)) ? LVL_MAX : $past(cfg_wdata[LVL_W-1:0]))))); // R3
    AST_NEG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[CFG_W-1]) |=> cfg_err); // R4
    AST_NEG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[CFG_W-1]) |=> ((cfg_addr != $past(cfg_addr)) || $stable(cfg_rdata))); // R4
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_wr && cfg_wdata[CFG_W-1])) |=> !cfg_err); // R4
endmodule

bind wtx_arb wtx_arb_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/sim_wtx_arb.sv
module sim_wtx_arb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int CFG_W      = 8;

    logic              clk;
    logic              rst_n;
    logic [2:0]        cls_valid;
    logic [3*DATA_W-1:0] cls_data;
    logic [2:0]        cls_eop;
    logic [2:0]        cls_ready;
    logic              link_valid;
    logic [DATA_W-1:0] link_data;
    logic              link_eop;
    logic [1:0]        link_cls;
    logic              link_ready;
    logic              cfg_wr;
    logic [1:0]        cfg_addr;
    logic [CFG_W-1:0]  cfg_wdata;
    logic [1:0]        cfg_rdata;
    logic              cfg_err;

    wtx_arb #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int act [3];
    int plen [3];
    int beat [3];
    int pcnt [3];
    int rdy_mode;
    int cyc;
    int glog [64];
    int gn;
    bit inpkt;
    int midcls;
    bit stalled;
    int stallcls;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] mk(int c, int p, int b);
        return {c[7:0], p[15:0], b[7:0]};
    endfunction

    task automatic check(bit ok, string req, longint actv, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actv, expv);
        end
    endtask

    task automatic drive_src();
        for (int i = 0; i < 3; i++) begin
            cls_valid[i] = (act[i] != 0);
            cls_eop[i]   = (beat[i] == plen[i] - 1);
            cls_data[i*DATA_W +: DATA_W] = mk(i, pcnt[i], beat[i]);
        end
        link_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    endtask

    // One cycle: drive at the falling edge, observe the handshake that the next rising edge takes.
    task automatic step();
        int c;
        @(negedge clk);
        drive_src();
        #1;
        c = int'(link_cls);
        if (stalled) check(link_valid && c == stallcls, "R9 class kept during stall", c, stallcls);
        stalled  = link_valid && !link_ready;
        stallcls = c;
        if (link_valid && link_ready) begin
            check(cls_ready == 3'(1 << c), "R10 ready of selected class", cls_ready, 1 << c);
            check(link_data == mk(c, pcnt[c], beat[c]), "R10 data of selected class", link_data, mk(c, pcnt[c], beat[c]));
            if (inpkt) check(c == midcls, "R8 class held within packet", c, midcls);
            if (link_eop) begin
                if (gn < 64) glog[gn] = c;
                gn++;
                beat[c]  = 0;
                pcnt[c]++;
                inpkt    = 0;
            end else begin
                beat[c]++;
                inpkt  = 1;
                midcls = c;
            end
        end else begin
            check(cls_ready == 3'b000, "R10 no ready without transfer", cls_ready, 0);
        end
        cyc++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int i = 0; i < 3; i++) begin
            act[i] = 0; plen[i] = 1; beat[i] = 0; pcnt[i] = 0;
        end
        rdy_mode = 0; cyc = 0; gn = 0; inpkt = 0; stalled = 0;
        drive_src();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write; returns at the falling edge after the capturing rising edge.
    task automatic cfg_write(int a, int v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_wdata = CFG_W'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_seq(int w0, int w1, int w2, int a0, int a1, int a2,
                           int mode, int l0, int l1, int l2, string req);
        int w [3];
        int expq [64];
        int n;
        int idx;
        int guard;
        do_reset();
        cfg_write(0, w0); cfg_write(1, w1); cfg_write(2, w2);
        w[0] = w0; w[1] = w1; w[2] = w2;
        act[0] = a0; act[1] = a1; act[2] = a2;
        plen[0] = l0; plen[1] = l1; plen[2] = l2;
        rdy_mode = mode;
        n = 0;
        for (int c = 0; c < 3; c++) if (act[c] != 0) n += w[c] + 1;
        n = 2 * n;
        idx = 0;
        while (idx < n) begin
            for (int c = 0; c < 3; c++)
                if (act[c] != 0)
                    for (int k = 0; k <= w[c]; k++)
                        if (idx < n) begin expq[idx] = c; idx++; end
        end
        guard = 0;
        while (gn < n && guard < 2000) begin
            step();
            guard++;
        end
        check(gn >= n, req, gn, n);
        for (int i = 0; i < n; i++)
            check(glog[i] == expq[i], req, glog[i], expq[i]);
    endtask

    initial begin
        do_reset();
        #1;
        // R2: reset levels, no error, idle link
        for (int a = 0; a < 3; a++) begin
            cfg_addr = 2'(a);
            #1;
            check(cfg_rdata == 2'd1, "R2 reset level", cfg_rdata, 1);
        end
        check(cfg_err == 1'b0, "R2 reset err", cfg_err, 0);
        check(link_valid == 1'b0, "R2 idle link", link_valid, 0);

        // R3: sweep all non-negative write values
        for (int v = 0; v < 128; v++) begin
            int exp_l;
            exp_l = (v > 2) ? 2 : v;
            cfg_write(v % 3, v);
            #1;
            check(cfg_rdata == 2'(exp_l), "R3 clamp", cfg_rdata, exp_l);
            check(cfg_err == 1'b0, "R4 no err on valid write", cfg_err, 0);
        end

        // R4: negative writes refused and flagged
        cfg_write(1, 1);
        for (int v = 128; v < 256; v += 9) begin
            cfg_write(1, v);
            #1;
            check(cfg_err == 1'b1, "R4 err on negative", cfg_err, 1);
            check(cfg_rdata == 2'd1, "R4 level kept", cfg_rdata, 1);
        end
        cfg_write(1, 0);
        #1;
        check(cfg_err == 1'b0, "R4 err cleared", cfg_err, 0);
        check(cfg_rdata == 2'd0, "R4 valid write after refusal", cfg_rdata, 0);

        // R1: address 3 ignored and reads zero
        cfg_write(0, 2); cfg_write(2, 1);
        cfg_write(3, 0);
        #1;
        check(cfg_rdata == 2'd0, "R1 unused address reads zero", cfg_rdata, 0);
        cfg_addr = 2'd0; #1;
        check(cfg_rdata == 2'd2, "R1 class 0 untouched", cfg_rdata, 2);
        cfg_addr = 2'd1; #1;
        check(cfg_rdata == 2'd0, "R1 class 1 untouched", cfg_rdata, 0);
        cfg_addr = 2'd2; #1;
        check(cfg_rdata == 2'd1, "R1 class 2 untouched", cfg_rdata, 1);

        // R5 and R6: every weight combination, single-beat and stalled multi-beat packets
        for (int w0 = 0; w0 < 3; w0++)
            for (int w1 = 0; w1 < 3; w1++)
                for (int w2 = 0; w2 < 3; w2++) begin
                    run_seq(w0, w1, w2, 1, 1, 1, 0, 1, 1, 1, "R5 slots per class");
                    run_seq(w0, w1, w2, 1, 1, 1, 1, 2, 1, 3, "R6 round order under stalls");
                end

        // R7: idle classes skipped, lone class served repeatedly
        run_seq(1, 2, 0, 1, 0, 1, 0, 1, 1, 1, "R7 idle non-posted skipped");
        run_seq(2, 1, 0, 0, 0, 1, 1, 1, 1, 2, "R7 lone posted class");
        run_seq(0, 2, 1, 0, 1, 1, 1, 3, 2, 1, "R7 idle completion skipped");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule